// File: doc/BRIEF.md
# Modem Call Tone Generator

This block produces the call-setup tones that a dial-up modem transmitter sends before data modulation starts. A seven-bit tone control word, a two-bit modulation family and an answer/originate flag pick one tone. The choices are a dual-frequency keypad (DTMF) pair, one of two guard tones, the calling tone, one of two answer tones, or the soft-carrier-turnoff tone. Selection is a fixed-priority decode that depends on the mode. The keypad enable beats everything else. The answer-tone request beats the shared guard/calling/turnoff request. The meaning of the low select bit depends on the answer flag and the modulation family.

The chosen tone drives two 24-bit phase accumulators. Their top ten bits address a quarter-wave sine table. Each accepted sample tick produces one signed 16-bit sample on a valid/ready output.

Back-pressure rules for the output:
- A tick is accepted when the output register is empty, or when it is being taken in that same cycle.
- A tick that arrives while a sample is held and not taken is dropped. The tone phase then does not move.
- The held sample, with its tone code and active flag, stays unchanged until the consumer takes it.

Top module: `modem_tone_gen`

## Requirements
- R1: When tone_ctrl[4] is 1, the keypad tone is selected (tone_code 1). This holds whatever the other control bits, the family or the answer flag are.
- R2: For the keypad tone, tone_ctrl[3:2] picks the low frequency from 697, 770, 852, 941 Hz (codes 0..3). tone_ctrl[1:0] picks the high frequency from 1209, 1336, 1477, 1633 Hz (codes 0..3). The sample is the sum of the two sines.
- R3: With tone_ctrl[5]=1 and tone_ctrl[4]=0, an answer tone plays only when answer_mode=1 and mod_family is 0 (four-level QAM) or 1 (two-phase DPSK). tone_ctrl[0]=0 gives 2225 Hz (code 5) and tone_ctrl[0]=1 gives 2100 Hz (code 6). Otherwise the output is silent. This request wins over tone_ctrl[6].
- R4: With tone_ctrl[6]=1, tone_ctrl[5:4]=0, answer_mode=1 and mod_family 0 or 1, a guard tone plays. tone_ctrl[0]=0 gives 1800 Hz (code 2) and tone_ctrl[0]=1 gives 550 Hz (code 3).
- R5: With tone_ctrl[6]=1, tone_ctrl[5:4]=0, tone_ctrl[0]=0, answer_mode=0 and mod_family 0, 1 or 2 (split-rate FSK), the 1300 Hz calling tone plays (code 4).
- R6: With tone_ctrl[6]=1, tone_ctrl[5:4]=0, tone_ctrl[0]=1, answer_mode=1 and mod_family 2, the 900 Hz turnoff tone plays (code 7).
- R7: Any other combination gives zero samples, tone_code 0 and tone_active 0. tone_active is 1 exactly when tone_code is nonzero. tone_ctrl[3:1] has no effect on non-keypad tones.
- R8: A single tone is round(16383*sin(2*pi*(k+0.5)/1024)), where k is the top ten bits of the accumulator. Each accepted tick adds round(f*2^24/9600) to the accumulator.
- R9: An accepted tick compares the selection (tone code, plus the digit for the keypad tone) with the previous one. If it differs, that tick's sample uses phase zero in both accumulators. If it matches, phase continues.
- R10: The inputs are sampled on the accepted tick, and the sample is valid one cycle later. A sample held with smp_ready=0 stays stable. Ticks dropped while stalled do not advance the phase. smp_ready with no tick clears smp_valid.
- R11: rst_n is an active-low synchronous reset. It clears smp_valid, smp_data, tone_active, tone_code, both accumulators and the stored selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tone_ctrl | input | 7 | Tone control word |
| mod_family | input | 2 | 0 QAM, 1 DPSK, 2 split-rate FSK, 3 other FSK |
| answer_mode | input | 1 | 1 answer, 0 originate |
| smp_tick | input | 1 | Sample-rate strobe (nominally 9600 Hz) |
| smp_ready | input | 1 | Consumer takes the held sample |
| smp_valid | output | 1 | Sample held for the consumer |
| smp_data | output | 16 | Signed tone sample |
| tone_active | output | 1 | A tone is selected for this sample |
| tone_code | output | 3 | Code of the tone in this sample |

## Verification
Some behaviours are checked on every cycle by assertions:
- The keypad override.
- The gating of the answer tone.
- Silence together with a cleared active flag whenever the code is zero.
- Stability of a held sample under back-pressure.
- No phase movement without an accepted tick.
- The phase restart when the selection changes.

Other behaviours only show up in the bench's scenarios, which compare sample values with a sine model:
- The actual frequencies.
- The keypad row/column mapping.
- Phase continuity across repeated selections and across ignored control bits.
- Silent dropping of ticks during a stall.

// File: rtl/cttg_pkg.sv
package cttg_pkg;

  typedef enum logic [2:0] {
    TC_NONE     = 3'd0,
    TC_DTMF     = 3'd1,
    TC_GUARD_HI = 3'd2,
    TC_GUARD_LO = 3'd3,
    TC_CALL     = 3'd4,
    TC_ANS_HI   = 3'd5,
    TC_ANS_LO   = 3'd6,
    TC_SCT      = 3'd7
  } tone_e;

  typedef enum logic [1:0] {
    FAM_QAM   = 2'd0,
    FAM_DPSK  = 2'd1,
    FAM_SPLIT = 2'd2,
    FAM_OTHER = 2'd3
  } fam_e;

  typedef struct packed {
    tone_e      code;
    logic [3:0] digit;
  } tone_sel_t;

  localparam int HZ_GUARD_HI = 1800;
  localparam int HZ_GUARD_LO = 550;
  localparam int HZ_CALL     = 1300;
  localparam int HZ_ANS_HI   = 2225;
  localparam int HZ_ANS_LO   = 2100;
  localparam int HZ_SCT      = 900;

  function automatic int row_hz(input int r);
    case (r)
      0:       return 697;
      1:       return 770;
      2:       return 852;
      default: return 941;
    endcase
  endfunction

  function automatic int col_hz(input int c);
    case (c)
      0:       return 1209;
      1:       return 1336;
      2:       return 1477;
      default: return 1633;
    endcase
  endfunction

endpackage

// File: rtl/cttg_decode.sv
module cttg_decode
  import cttg_pkg::*;
(
  input  logic [6:0] ctrl,
  input  logic [1:0] family,
  input  logic       answer,
  output tone_sel_t  sel
);
  logic dpsk_like;
  logic split_fsk;

  assign dpsk_like = (family == FAM_QAM) || (family == FAM_DPSK);
  assign split_fsk = (family == FAM_SPLIT);

  always_comb begin
    sel.code  = TC_NONE;
    sel.digit = 4'd0;
    if (ctrl[4]) begin
      sel.code  = TC_DTMF;
      sel.digit = ctrl[3:0];
    end else if (ctrl[5]) begin
      if (answer && dpsk_like) sel.code = ctrl[0] ? TC_ANS_LO : TC_ANS_HI;
    end else if (ctrl[6]) begin
      if (!ctrl[0]) begin
        if (answer && dpsk_like)                     sel.code = TC_GUARD_HI;
        else if (!answer && (dpsk_like || split_fsk)) sel.code = TC_CALL;
      end else begin
        if (answer && dpsk_like)      sel.code = TC_GUARD_LO;
        else if (answer && split_fsk) sel.code = TC_SCT;
      end
    end
  end
endmodule

// File: rtl/cttg_sine.sv
module cttg_sine #(
  parameter int PH_W  = 10,
  parameter int OUT_W = 15
) (
  input  logic [PH_W-1:0]         phase,
  output logic signed [OUT_W-1:0] sample
);
  localparam int    QN     = 1 << (PH_W - 2);
  localparam int    MW     = OUT_W - 1;
  localparam longint AMP   = (longint'(1) << MW) - 1;
  localparam int    FX     = 28;
  localparam longint ONE   = longint'(1) << FX;
  localparam longint PI_FX = 64'd843314857;

  function automatic logic [QN*MW-1:0] build_lut();
    logic [QN*MW-1:0] t;
    longint x, x2, p, s, v;
    t = '0;
    for (int i = 0; i < QN; i++) begin
      x  = (longint'(2 * i + 1) * PI_FX) / longint'(4 * QN);
      x2 = (x * x) >>> FX;
      p  = ONE - x2 / 72;
      p  = ONE - ((x2 * p) >>> FX) / 42;
      p  = ONE - ((x2 * p) >>> FX) / 20;
      p  = ONE - ((x2 * p) >>> FX) / 6;
      s  = (x * p) >>> FX;
      v  = (s * AMP + (ONE >>> 1)) >>> FX;
      if (v > AMP) v = AMP;
      t[i*MW +: MW] = MW'(v);
    end
    return t;
  endfunction

  localparam logic [QN*MW-1:0] LUT = build_lut();

  logic [PH_W-3:0] idx;
  logic [PH_W-3:0] fold_idx;
  logic [MW-1:0]   mag;

  assign idx      = phase[PH_W-3:0];
  assign fold_idx = phase[PH_W-2] ? ~idx : idx;
  assign mag      = LUT[fold_idx*MW +: MW];
  assign sample   = phase[PH_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
endmodule

// File: rtl/modem_tone_gen.sv
module modem_tone_gen
  import cttg_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int FS_HZ = 9600,
  parameter int PH_W  = 10,
  parameter int SW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    tone_ctrl,
  input  logic [1:0]    mod_family,
  input  logic          answer_mode,
  input  logic          smp_tick,
  input  logic          smp_ready,
  output logic          smp_valid,
  output logic [SW-1:0] smp_data,
  output logic          tone_active,
  output logic [2:0]    tone_code
);
  localparam int SINE_W = SW - 1;
  localparam int N_OSC  = 2;

  function automatic logic [ACC_W-1:0] step_of(input int hz);
    longint num;
    num = (longint'(hz) <<< ACC_W) + longint'(FS_HZ / 2);
    return ACC_W'(num / longint'(FS_HZ));
  endfunction

  localparam logic [ACC_W-1:0] ROW_STEP [4] =
    '{step_of(row_hz(0)), step_of(row_hz(1)), step_of(row_hz(2)), step_of(row_hz(3))};
  localparam logic [ACC_W-1:0] COL_STEP [4] =
    '{step_of(col_hz(0)), step_of(col_hz(1)), step_of(col_hz(2)), step_of(col_hz(3))};

  tone_sel_t cur_sel, sel_q;
  tone_e     code_q;
  logic      accept, restart;
  logic [ACC_W-1:0] acc_q [N_OSC];
  logic [ACC_W-1:0] base  [N_OSC];
  logic [ACC_W-1:0] inc   [N_OSC];
  logic signed [SINE_W-1:0] sine_s [N_OSC];
  logic signed [SW-1:0]     mix;

  cttg_decode u_dec (
    .ctrl   (tone_ctrl),
    .family (mod_family),
    .answer (answer_mode),
    .sel    (cur_sel)
  );

  assign accept  = smp_tick && (!smp_valid || smp_ready);
  assign restart = (cur_sel != sel_q);

  always_comb begin
    inc[0] = '0;
    inc[1] = '0;
    unique case (cur_sel.code)
      TC_DTMF: begin
        inc[0] = ROW_STEP[cur_sel.digit[3:2]];
        inc[1] = COL_STEP[cur_sel.digit[1:0]];
      end
      TC_GUARD_HI: inc[0] = step_of(HZ_GUARD_HI);
      TC_GUARD_LO: inc[0] = step_of(HZ_GUARD_LO);
      TC_CALL:     inc[0] = step_of(HZ_CALL);
      TC_ANS_HI:   inc[0] = step_of(HZ_ANS_HI);
      TC_ANS_LO:   inc[0] = step_of(HZ_ANS_LO);
      TC_SCT:      inc[0] = step_of(HZ_SCT);
      default:     inc[0] = '0;
    endcase
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    assign base[g] = restart ? '0 : acc_q[g];
    cttg_sine #(.PH_W(PH_W), .OUT_W(SINE_W)) u_sine (
      .phase  (base[g][ACC_W-1 -: PH_W]),
      .sample (sine_s[g])
    );
  end

  always_comb begin
    case (cur_sel.code)
      TC_NONE: mix = '0;
      TC_DTMF: mix = SW'(sine_s[0]) + SW'(sine_s[1]);
      default: mix = SW'(sine_s[0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid   <= 1'b0;
      smp_data    <= '0;
      tone_active <= 1'b0;
      code_q      <= TC_NONE;
      sel_q       <= '{code: TC_NONE, digit: 4'd0};
      for (int i = 0; i < N_OSC; i++) acc_q[i] <= '0;
    end else if (accept) begin
      smp_valid   <= 1'b1;
      smp_data    <= mix;
      tone_active <= (cur_sel.code != TC_NONE);
      code_q      <= cur_sel.code;
      sel_q       <= cur_sel;
      for (int i = 0; i < N_OSC; i++) acc_q[i] <= base[i] + inc[i];
    end else if (smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

  assign tone_code = code_q;

  AST_DTMF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && tone_ctrl[4] |=> tone_code == 3'd1); // R1
  AST_ANS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && tone_ctrl[5] && !tone_ctrl[4] && !(answer_mode && !mod_family[1])
    |=> tone_code == 3'd0); // R3
  AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && tone_code == 3'd0 |-> smp_data == '0 && !tone_active); // R7
  AST_ACTIVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && tone_code != 3'd0 |-> tone_active); // R7
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    accept && restart |=> acc_q[0] == $past(inc[0]) && acc_q[1] == $past(inc[1])); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(tone_code)); // R10
  AST_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(acc_q[0]) && $stable(acc_q[1])); // R10
endmodule

// File: tb/modem_tone_gen_tb_top.sv
module modem_tone_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  tone_ctrl = '0;
  logic [1:0]  mod_family = '0;
  logic        answer_mode = 1'b0;
  logic        smp_tick = 1'b0;
  logic        smp_ready = 1'b1;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic        tone_active;
  logic [2:0]  tone_code;

  int n_chk = 0;
  int n_err = 0;
  int unsigned ma = 0, mb = 0;
  int pcode = 0;
  int pdig = 0;

  always #2 clk = ~clk;

  modem_tone_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tone_ctrl(tone_ctrl), .mod_family(mod_family),
    .answer_mode(answer_mode), .smp_tick(smp_tick), .smp_ready(smp_ready),
    .smp_valid(smp_valid), .smp_data(smp_data), .tone_active(tone_active),
    .tone_code(tone_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [6:0] c, input logic [1:0] f, input logic a);
    bit dl, v23;
    dl  = (f == 2'd0) || (f == 2'd1);
    v23 = (f == 2'd2);
    if (c[4]) return 1;
    if (c[5]) return (a && dl) ? (c[0] ? 6 : 5) : 0;
    if (c[6]) begin
      if (!c[0]) return (a && dl) ? 2 : ((!a && (dl || v23)) ? 4 : 0);
      return (a && dl) ? 3 : ((a && v23) ? 7 : 0);
    end
    return 0;
  endfunction

  function automatic int hz_a(input int code, input int d);
    int rows[4] = '{697, 770, 852, 941};
    case (code)
      1: return rows[(d >> 2) & 3];
      2: return 1800;
      3: return 550;
      4: return 1300;
      5: return 2225;
      6: return 2100;
      7: return 900;
      default: return 0;
    endcase
  endfunction

  function automatic int hz_b(input int code, input int d);
    int cols[4] = '{1209, 1336, 1477, 1633};
    return (code == 1) ? cols[d & 3] : 0;
  endfunction

  function automatic int unsigned step(input int hz);
    return $rtoi(real'(hz) * 16777216.0 / 9600.0 + 0.5);
  endfunction

  function automatic int sine_at(input int unsigned acc);
    real v;
    v = 16383.0 * $sin(2.0 * 3.141592653589793 * (real'(acc >> 14) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic tick_once(input logic [6:0] c, input logic [1:0] f, input logic a, input string req);
    int code, dig, es, act;
    tone_ctrl = c; mod_family = f; answer_mode = a;
    smp_tick = 1'b1; smp_ready = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
    code = exp_code(c, f, a);
    dig  = (code == 1) ? int'(c[3:0]) : 0;
    if (code != pcode || dig != pdig) begin ma = 0; mb = 0; end  // R9
    if (code == 0)      es = 0;
    else if (code == 1) es = sine_at(ma) + sine_at(mb);
    else                es = sine_at(ma);
    ma = (ma + step(hz_a(code, dig))) & 32'hFFFFFF;
    mb = (mb + step(hz_b(code, dig))) & 32'hFFFFFF;
    pcode = code; pdig = dig;
    act = int'($signed(smp_data));
    chk(smp_valid == 1'b1, {req, " R10 valid"}, int'(smp_valid), 1);
    chk(int'(tone_code) == code, {req, " code"}, int'(tone_code), code);
    chk(tone_active == (code != 0), {req, " R7 active"}, int'(tone_active), int'(code != 0));
    chk((act - es <= 2) && (es - act <= 2), {req, " R8 sample"}, act, es);
  endtask

  task automatic run(input logic [6:0] c, input logic [1:0] f, input logic a, input int n, input string req);
    for (int i = 0; i < n; i++) tick_once(c, f, a, req);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(smp_valid == 0 && tone_active == 0 && tone_code == 0 && smp_data == 0,
        "R11 reset outputs", int'(smp_data), 0);
    run(7'h00, 2'd0, 1'b0, 4, "R7 idle");
    // R1 override with every other bit set
    run(7'h7F, 2'd2, 1'b1, 10, "R1 override");
    // R2 all keypad digits
    for (int d = 0; d < 16; d++) run(7'h10 | 7'(d), 2'(d % 4), 1'(d % 2), 6, "R2 digit");
    // R3 answer tones and gating
    run(7'h20, 2'd0, 1'b1, 12, "R3 ans 2225");
    run(7'h21, 2'd1, 1'b1, 12, "R3 ans 2100");
    run(7'h60, 2'd0, 1'b1, 6, "R3 beats bit6");
    run(7'h20, 2'd2, 1'b1, 4, "R3 not dpsk");
    run(7'h21, 2'd0, 1'b0, 4, "R3 originate");
    // R4 guard tones
    run(7'h40, 2'd1, 1'b1, 12, "R4 guard 1800");
    run(7'h41, 2'd0, 1'b1, 12, "R4 guard 550");
    // R7 bits 3:1 ignored: phase continues across these
    run(7'h4E, 2'd1, 1'b1, 5, "R7 ignore bits");
    run(7'h4A, 2'd1, 1'b1, 5, "R7 ignore bits");
    // R5 calling tone
    run(7'h40, 2'd2, 1'b0, 12, "R5 call v23");
    run(7'h40, 2'd0, 1'b0, 6, "R5 call qam");
    run(7'h40, 2'd3, 1'b0, 4, "R5 other fsk silent");
    run(7'h41, 2'd1, 1'b0, 4, "R5 bit0 set silent");
    // R6 turnoff tone
    run(7'h41, 2'd2, 1'b1, 12, "R6 sct 900");
    run(7'h40, 2'd2, 1'b1, 4, "R6 bit0 clear silent");
    // R10 stall: held sample stable, dropped ticks do not advance phase
    run(7'h40, 2'd0, 1'b1, 3, "R10 pre-stall");
    held = smp_data;
    smp_ready = 1'b0; smp_tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(smp_valid == 1'b1 && smp_data == held, "R10 hold", int'(smp_data), int'(held));
    end
    smp_tick = 1'b0; smp_ready = 1'b1;
    @(negedge clk);
    chk(smp_valid == 1'b0, "R10 drain", int'(smp_valid), 0);
    run(7'h40, 2'd0, 1'b1, 4, "R10 resume phase");
    // R11 mid-run reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(smp_valid == 0 && tone_active == 0 && tone_code == 0 && smp_data == 0,
        "R11 reset mid-run", int'(tone_code), 0);
    pcode = 0; pdig = 0; ma = 0; mb = 0;
    // random segments
    for (int s = 0; s < 300; s++) begin
      logic [6:0] c;
      c = 7'($urandom) & (($urandom % 2) ? 7'h7F : 7'h6F);
      run(c, 2'($urandom), 1'($urandom), 1 + int'($urandom % 12), "random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule